// File: doc/BRIEF.md
# Thermal Shutdown Sequencer for Eight Output Channels

This block decides, cycle by cycle, whether each of eight power output channels may conduct. Its inputs are digital comparator flags from the temperature sensors: for every channel, a junction-hot flag (above the shutdown threshold) and a junction-cool flag (below the lower reset threshold). For the whole package there is one case-hot flag and one case-cool flag. Each flag passes through a persistence filter before the controller acts on it. A channel that trips on its junction turns itself off and restarts on its own once its junction is cool again, as long as it is still commanded on. The gap between the two thresholds gives the hysteresis.

If the case overheats while one or more channels are already off for junction heat, those channels latch off. They stay off until the case is cool and every latched or junction-faulted channel is cool too. Channels that never tripped keep running through the case event. The block also keeps a per-channel fault vector and a common active-low fault line. The fault vector is copied into a host-visible snapshot only when a transfer strobe arrives, so the snapshot may lag. Protection on the drive outputs never waits for that strobe.

Top module: `tsd_ctrl`

## Requirements
- R1: A channel whose filtered junction-hot flag is set is switched off (its `ch_drive` bit, where bit i is channel i, goes to 0) on the clock edge after the filter output rises, whatever its command.
- R2: A junction-tripped channel restarts only after its filtered junction-cool flag is set. Clearing the hot flag alone, while the channel is in the hysteresis band, leaves the channel off. After restart it follows `cmd_on` again.
- R3: A raw flag change reaches the controller only after it has held for FILT_CYCLES consecutive clock edges. A shorter pulse has no effect on any output.
- R4: When the case-hot flag is set while a channel is junction-tripped, that channel latches off. It is released only when the case-cool flag is set and every faulted channel's junction-cool flag is set.
- R5: Channels that are not faulted keep following `cmd_on` during a case over-temperature.
- R6: The fault bit of a channel (bit i of the vector, 1 = faulted) is 1 while the channel is tripped or latched, whether it is commanded on or off.
- R7: `fault_n` is 0 exactly when at least one faulted channel is commanded on. It stays 1 for faults on channels that are commanded off.
- R8: `fault_snap` copies the live fault vector on a clock edge where `xfer_strobe` is 1 and holds its value at all other times.
- R9: Switching a channel off for heat does not depend on `xfer_strobe`.
- R10: After reset, every channel is in normal operation, so `ch_drive` equals `cmd_on`, `fault_snap` is 0 and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_on | input | NCH | Commanded on/off per channel, 1 = on |
| jct_hot | input | NCH | Raw junction above-shutdown flags |
| jct_cool | input | NCH | Raw junction below-reset flags |
| case_hot | input | 1 | Raw case above-shutdown flag |
| case_cool | input | 1 | Raw case below-reset flag |
| xfer_strobe | input | 1 | Inter-stage transfer: refresh fault snapshot |
| ch_drive | output | NCH | Gated drive per channel, 1 = conducting |
| fault_snap | output | NCH | Last captured fault vector |
| fault_n | output | 1 | Common fault, active low |

## Verification
The bench builds the block with eight channels and a persistence length of three cycles. With that length, the filter's exact boundary can be reached in a few cycles: a two-cycle pulse must be ignored, while a held flag acts after three edges plus one more for the state update. Eight channels allow scenarios in which one channel stays latched for a case event while the others keep running, and in which two faulted channels cool at different times.

// File: rtl/tsd_pkg.sv
// Shared types for the thermal shutdown sequencer.
package tsd_pkg;
    // Per-channel protection state.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,  // normal: drive follows command
        ST_JOFF  = 2'd1,  // junction trip, auto-restart pending
        ST_CHOLD = 2'd2   // latched by case over-temperature
    } tsd_state_t;
endpackage

// File: rtl/tsd_persist.sv
// Persistence filter: the output takes the raw value only after the raw
// input has differed from the output on FILT_CYCLES consecutive edges.
// Assumes the raw flag is already synchronous to clk.
module tsd_persist #(
    parameter int FILT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic [CW-1:0] run_cnt;

    // Count a disagreeing run; commit when it reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            filt    <= 1'b0;
        end else if (raw == filt) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_CYCLES - 1)) begin
            run_cnt <= '0;
            filt    <= raw;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R3: the filtered value only ever moves to the raw value just seen
    a_r3_flip_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> (filt == $past(raw)));
endmodule

// File: rtl/tsd_chan.sv
// One channel's protection state machine. Junction trips restart on their
// own; a case trip while tripped latches the channel until release.
// Assumes all flags are already filtered.
module tsd_chan
    import tsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hot,
    input  logic       cool,
    input  logic       case_hot_f,
    input  logic       release_ok,
    output tsd_state_t state
);
    tsd_state_t nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:   if (hot) nxt = ST_JOFF;
            ST_JOFF:  if (case_hot_f) nxt = ST_CHOLD;
                      else if (cool) nxt = ST_RUN;
            ST_CHOLD: if (release_ok) nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // R4: a latched channel stays latched until release is granted
    a_r4_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHOLD && !release_ok) |=> (state == ST_CHOLD));
    // R2: leaving a junction trip without a case event needs the cool flag
    a_r2_restart_needs_cool: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JOFF && !cool && !case_hot_f) |=> (state == ST_JOFF));
endmodule

// File: rtl/tsd_ctrl.sv
// Thermal shutdown sequencer top: filters the comparator flags, runs one
// protection machine per channel, gates the drives and keeps the fault
// vector, its host-side snapshot and the common active-low fault line.
// Assumes all inputs are synchronous to clk.
module tsd_ctrl
    import tsd_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int FILT_CYCLES = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmd_on,
    input  logic [NCH-1:0] jct_hot,
    input  logic [NCH-1:0] jct_cool,
    input  logic           case_hot,
    input  logic           case_cool,
    input  logic           xfer_strobe,
    output logic [NCH-1:0] ch_drive,
    output logic [NCH-1:0] fault_snap,
    output logic           fault_n
);
    logic [NCH-1:0] hot_f, cool_f, faulted;
    logic           case_hot_f, case_cool_f, release_ok;
    tsd_state_t     st [NCH];

    // Package-level flag filters.
    tsd_persist #(.FILT_CYCLES(FILT_CYCLES)) u_case_hot (
        .clk(clk), .rst_n(rst_n), .raw(case_hot), .filt(case_hot_f));
    tsd_persist #(.FILT_CYCLES(FILT_CYCLES)) u_case_cool (
        .clk(clk), .rst_n(rst_n), .raw(case_cool), .filt(case_cool_f));

    // Release a case latch when the case and all faulted junctions are cool.
    assign release_ok = case_cool_f && ((faulted & ~cool_f) == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tsd_persist #(.FILT_CYCLES(FILT_CYCLES)) u_hot (
            .clk(clk), .rst_n(rst_n), .raw(jct_hot[i]), .filt(hot_f[i]));
        tsd_persist #(.FILT_CYCLES(FILT_CYCLES)) u_cool (
            .clk(clk), .rst_n(rst_n), .raw(jct_cool[i]), .filt(cool_f[i]));
        tsd_chan u_chan (
            .clk(clk), .rst_n(rst_n), .hot(hot_f[i]), .cool(cool_f[i]),
            .case_hot_f(case_hot_f), .release_ok(release_ok), .state(st[i]));

        // Gate the drive and flag the fault for this channel.
        assign faulted[i]  = (st[i] != ST_RUN);
        assign ch_drive[i] = cmd_on[i] && (st[i] == ST_RUN);

        // R1: a filtered junction trip removes drive on the next edge
        a_r1_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
            hot_f[i] |=> !ch_drive[i]);
    end

    // Common fault: a faulted channel that the host wants on.
    assign fault_n = ((faulted & cmd_on) == '0);

    // Host-side snapshot, refreshed only on a transfer strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           fault_snap <= '0;
        else if (xfer_strobe) fault_snap <= faulted;
    end

    // R8: no strobe, no snapshot change
    a_r8_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_strobe |=> $stable(fault_snap));
    // R7: an active fault line means some commanded channel is not driven
    a_r7_fault_means_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (ch_drive != cmd_on));
    // R5: with no channel faulted the drives follow the command
    a_r5_unfaulted_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (faulted == '0) |-> (ch_drive == cmd_on));
endmodule

// File: tb/test_tsd_ctrl.sv
module test_tsd_ctrl;
    localparam int NCH  = 8;
    localparam int FILT = 3;
    localparam int LAT  = FILT + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] cmd_on = '0;
    logic [NCH-1:0] jct_hot = '0;
    logic [NCH-1:0] jct_cool = '1;
    logic           case_hot = 1'b0;
    logic           case_cool = 1'b1;
    logic           xfer_strobe = 1'b0;
    logic [NCH-1:0] ch_drive, fault_snap;
    logic           fault_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    tsd_ctrl #(.NCH(NCH), .FILT_CYCLES(FILT)) i_tsd_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .jct_hot(jct_hot),
        .jct_cool(jct_cool), .case_hot(case_hot), .case_cool(case_cool),
        .xfer_strobe(xfer_strobe), .ch_drive(ch_drive),
        .fault_snap(fault_snap), .fault_n(fault_n));

    always #2.5 clk = ~clk;

    task automatic chk(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        xfer_strobe = 1'b1;
        step(1);
        xfer_strobe = 1'b0;
    endtask

    task automatic heat(int ch);
        jct_hot[ch] = 1'b1; jct_cool[ch] = 1'b0;
    endtask

    task automatic cool_down(int ch);
        jct_hot[ch] = 1'b0; jct_cool[ch] = 1'b1;
    endtask

    task automatic t_reset();
        cmd_on = 8'hA5;
        step(2);
        rst_n = 1'b1;
        step(1);
        chk("R10 drive", ch_drive, 8'hA5);
        chk("R10 snap", fault_snap, 8'h00);
        chk("R10 fault_n", {7'd0, fault_n}, 8'h01);
    endtask

    task automatic t_trip_restart();
        cmd_on = 8'hFF;
        heat(2);
        step(LAT);
        chk("R1 trip off", ch_drive, 8'hFB);
        chk("R9 no strobe needed", fault_snap, 8'h00);
        chk("R7 fault_n low", {7'd0, fault_n}, 8'h00);
        strobe();
        chk("R8 snap captured", fault_snap, 8'h04);
        jct_hot[2] = 1'b0;
        step(LAT + 2);
        chk("R2 hysteresis band stays off", ch_drive, 8'hFB);
        jct_cool[2] = 1'b1;
        step(LAT);
        chk("R2 restart", ch_drive, 8'hFF);
        chk("R8 snap stale", fault_snap, 8'h04);
        strobe();
        chk("R8 snap cleared", fault_snap, 8'h00);
        cmd_on = 8'h0F;
        step(1);
        chk("R2 follows cmd", ch_drive, 8'h0F);
        cmd_on = 8'hFF;
    endtask

    task automatic t_fault_off_cmd();
        cmd_on = 8'hFE;
        heat(0);
        step(LAT);
        strobe();
        chk("R6 fault bit with cmd off", fault_snap, 8'h01);
        chk("R7 fault_n high for cmd off", {7'd0, fault_n}, 8'h01);
        cool_down(0);
        step(LAT);
        strobe();
        cmd_on = 8'hFF;
        step(1);
        chk("R6 cleared", fault_snap, 8'h00);
    endtask

    task automatic t_glitch();
        jct_hot[4] = 1'b1;
        step(FILT - 1);
        jct_hot[4] = 1'b0;
        step(LAT + 2);
        chk("R3 short pulse ignored", ch_drive, 8'hFF);
        chk("R3 fault_n", {7'd0, fault_n}, 8'h01);
        case_hot = 1'b1;
        step(FILT - 1);
        case_hot = 1'b0;
        heat(4);
        step(LAT + 1);
        chk("R3 case glitch no latch", ch_drive, 8'hEF);
        cool_down(4);
        step(LAT + 1);
        chk("R3 restart after glitch", ch_drive, 8'hFF);
    endtask

    task automatic t_case_single();
        heat(3);
        step(LAT);
        case_hot = 1'b1; case_cool = 1'b0;
        step(LAT);
        chk("R5 others run", ch_drive, 8'hF7);
        cool_down(3);
        step(LAT + 2);
        chk("R4 held while case hot", ch_drive, 8'hF7);
        case_hot = 1'b0;
        step(LAT + 2);
        chk("R4 held in case band", ch_drive, 8'hF7);
        case_cool = 1'b1;
        step(LAT);
        chk("R4 released", ch_drive, 8'hFF);
    endtask

    task automatic t_case_two();
        heat(5); heat(6);
        step(LAT);
        case_hot = 1'b1; case_cool = 1'b0;
        step(LAT);
        chk("R4 two latched", ch_drive, 8'h9F);
        case_hot = 1'b0; case_cool = 1'b1;
        step(LAT + 2);
        chk("R4 case cool junctions hot", ch_drive, 8'h9F);
        cool_down(5);
        step(LAT + 2);
        chk("R4 one junction still hot", ch_drive, 8'h9F);
        strobe();
        chk("R6 latched faults", fault_snap, 8'h60);
        cool_down(6);
        step(LAT);
        chk("R4 all released", ch_drive, 8'hFF);
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_trip_restart();
        t_fault_off_cmd();
        t_glitch();
        t_case_single();
        t_case_two();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule